// File: doc/BRIEF.md
# Double-Pulse Reset Sequencer

This block produces a fixed-shape reset waveform for downstream logic that needs its reset applied twice, each time for a minimum number of cycles. A single-cycle start request launches the sequence. The block first waits through a quiet lead-in with the reset output low. It then drives a reset pulse, holds a low gap of the same length, and drives a second pulse of the same length. A short quiet tail follows, and the block then flags completion.

The pulse length comes from a 16-bit width input and is captured when the start request is accepted. Any value below the configured floor of 110 cycles is raised to that floor, so a zero or small request still gives a safe pulse. A busy output covers the whole sequence. Start requests made while busy are dropped. A synchronous system reset aborts any sequence in progress and returns the output to low.

Top module: `dprs_seq`

## Requirements
- R1: After the system reset `srst` has been applied, `reset_pulse_o`, `busy_o` and `done_o` are all 0.
- R2: When `start_i` is sampled high while idle, `busy_o` is high from the next cycle onward and `reset_pulse_o` stays 0 for the first 10 cycles of the sequence (cycles 0 to 9).
- R3: With effective width N, `reset_pulse_o` is 1 in cycles 10 to 10+N-1, 0 in cycles 10+N to 10+2N-1, and 1 in cycles 10+2N to 10+3N-1.
- R4: The effective width N equals `pulse_width_i` when that value is 110 or more, and 110 otherwise (0 included).
- R5: After the second pulse `reset_pulse_o` is 0 for 5 cycles. `done_o` is 1 only in the last of these cycles (cycle 10+3N+4), and in the cycle after it `busy_o` is 0.
- R6: `busy_o` is 1 in exactly cycles 0 to 10+3N+4 of a sequence, and `reset_pulse_o` and `done_o` are never 1 while `busy_o` is 0.
- R7: `start_i` held high in any cycle while `busy_o` is 1 has no effect on the waveform or on the sequence length.
- R8: `pulse_width_i` is captured in the cycle the start is accepted, and changes to it later in the sequence do not change N.
- R9: Asserting `srst` during a sequence makes `reset_pulse_o`, `busy_o` and `done_o` 0 in the next cycle. The block then remains idle until a new start.
- R10: A start sampled in the first idle cycle after `done_o` is accepted and launches a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high system reset |
| start_i | input | 1 | Start request, sampled on the rising edge |
| pulse_width_i | input | 16 | Requested pulse and gap length in cycles |
| reset_pulse_o | output | 1 | Generated reset for downstream logic |
| busy_o | output | 1 | High while a sequence is in progress |
| done_o | output | 1 | Single-cycle completion pulse |

## Verification
The assertions check these properties on every cycle:
- the reset output and the completion pulse never appear outside busy;
- done lasts exactly one cycle and busy falls only right after it;
- an idle start always raises busy;
- every reset pulse lasts at least the floor length.

The exact phase boundaries, the clamp value, and the immunity to mid-sequence start and width changes need known stimulus and a cycle-accurate model. Those are shown only by the bench's sequences, which compare every cycle against the expected waveform.

// File: rtl/dprs_pkg.sv
package dprs_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_LEAD = 3'd1,
      PH_HIGH = 3'd2,
      PH_GAP  = 3'd3,
      PH_TAIL = 3'd4
   } phase_e;

endpackage

// File: rtl/dprs_width_latch.sv
module dprs_width_latch #(
   parameter int WIDTH_W   = 16,
   parameter int MIN_PULSE = 110
) (
   input  logic               clk,
   input  logic               srst,
   input  logic               capture,
   input  logic [WIDTH_W-1:0] req_width,
   output logic [WIDTH_W-1:0] eff_width
);

   localparam logic [WIDTH_W-1:0] FLOOR = WIDTH_W'(MIN_PULSE);

   logic [WIDTH_W-1:0] clamped;

   generate
      if (MIN_PULSE > 1) begin : g_floor_cmp
         always_comb clamped = (req_width < FLOOR) ? FLOOR : req_width;
      end else begin : g_zero_fix
         always_comb clamped = (req_width == '0) ? WIDTH_W'(1) : req_width;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (srst)
         eff_width <= FLOOR;
      else if (capture)
         eff_width <= clamped;
   end

endmodule

// File: rtl/dprs_down_counter.sv
module dprs_down_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             at_zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (srst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/dprs_phase_ctrl.sv
module dprs_phase_ctrl
   import dprs_pkg::*;
#(
   parameter int WIDTH_W    = 16,
   parameter int CNT_W      = 16,
   parameter int LEAD_CYC   = 10,
   parameter int TAIL_CYC   = 5,
   parameter int NUM_PULSES = 2
) (
   input  logic               clk,
   input  logic               srst,
   input  logic               start,
   input  logic               cnt_zero,
   input  logic [WIDTH_W-1:0] eff_width,
   output logic               cnt_load,
   output logic [CNT_W-1:0]   cnt_val,
   output logic               accept,
   output phase_e             phase
);

   localparam int IDX_W = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PULSES - 1);
   localparam logic [CNT_W-1:0] LEAD_LD  = CNT_W'(LEAD_CYC - 1);
   localparam logic [CNT_W-1:0] TAIL_LD  = CNT_W'(TAIL_CYC - 1);

   phase_e           ph_q, ph_n;
   logic [IDX_W-1:0] idx_q, idx_n;
   logic [CNT_W-1:0] width_ld;

   assign width_ld = CNT_W'(eff_width) - CNT_W'(1);
   assign accept   = (ph_q == PH_IDLE) && start;

   always_comb begin
      ph_n     = ph_q;
      idx_n    = idx_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      unique case (ph_q)
         PH_IDLE: begin
            if (start) begin
               ph_n     = PH_LEAD;
               cnt_load = 1'b1;
               cnt_val  = LEAD_LD;
            end
         end
         PH_LEAD: begin
            if (cnt_zero) begin
               ph_n     = PH_HIGH;
               idx_n    = '0;
               cnt_load = 1'b1;
               cnt_val  = width_ld;
            end
         end
         PH_HIGH: begin
            if (cnt_zero) begin
               cnt_load = 1'b1;
               if (idx_q == LAST_IDX) begin
                  ph_n    = PH_TAIL;
                  cnt_val = TAIL_LD;
               end else begin
                  ph_n    = PH_GAP;
                  cnt_val = width_ld;
               end
            end
         end
         PH_GAP: begin
            if (cnt_zero) begin
               ph_n     = PH_HIGH;
               idx_n    = idx_q + IDX_W'(1);
               cnt_load = 1'b1;
               cnt_val  = width_ld;
            end
         end
         PH_TAIL: begin
            if (cnt_zero)
               ph_n = PH_IDLE;
         end
         default: ph_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (srst) begin
         ph_q  <= PH_IDLE;
         idx_q <= '0;
      end else begin
         ph_q  <= ph_n;
         idx_q <= idx_n;
      end
   end

   assign phase = ph_q;

endmodule

// File: rtl/dprs_seq.sv
module dprs_seq
   import dprs_pkg::*;
#(
   parameter int WIDTH_W    = 16,
   parameter int MIN_PULSE  = 110,
   parameter int LEAD_CYC   = 10,
   parameter int TAIL_CYC   = 5,
   parameter int NUM_PULSES = 2
) (
   input  logic               clk,
   input  logic               srst,
   input  logic               start_i,
   input  logic [WIDTH_W-1:0] pulse_width_i,
   output logic               reset_pulse_o,
   output logic               busy_o,
   output logic               done_o
);

   localparam int LEAD_W = $clog2(LEAD_CYC + 1);
   localparam int TAIL_W = $clog2(TAIL_CYC + 1);
   localparam int AUX_W  = (LEAD_W > TAIL_W) ? LEAD_W : TAIL_W;
   localparam int CNT_W  = (WIDTH_W > AUX_W) ? WIDTH_W : AUX_W;

   generate
      if (WIDTH_W < 2)
         $error("dprs_seq: WIDTH_W must be at least 2");
      if (MIN_PULSE < 1 || MIN_PULSE >= (1 << WIDTH_W))
         $error("dprs_seq: MIN_PULSE must be in 1 .. 2**WIDTH_W-1");
      if (LEAD_CYC < 1)
         $error("dprs_seq: LEAD_CYC must be at least 1");
      if (TAIL_CYC < 1)
         $error("dprs_seq: TAIL_CYC must be at least 1");
      if (NUM_PULSES < 1)
         $error("dprs_seq: NUM_PULSES must be at least 1");
   endgenerate

   logic               accept;
   logic               cnt_load;
   logic               cnt_zero;
   logic [CNT_W-1:0]   cnt_val;
   logic [WIDTH_W-1:0] eff_width;
   phase_e             phase;

   dprs_width_latch #(
      .WIDTH_W   (WIDTH_W),
      .MIN_PULSE (MIN_PULSE)
   ) u_width (
      .clk       (clk),
      .srst      (srst),
      .capture   (accept),
      .req_width (pulse_width_i),
      .eff_width (eff_width)
   );

   dprs_down_counter #(
      .CNT_W    (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .srst     (srst),
      .load     (cnt_load),
      .load_val (cnt_val),
      .at_zero  (cnt_zero)
   );

   dprs_phase_ctrl #(
      .WIDTH_W    (WIDTH_W),
      .CNT_W      (CNT_W),
      .LEAD_CYC   (LEAD_CYC),
      .TAIL_CYC   (TAIL_CYC),
      .NUM_PULSES (NUM_PULSES)
   ) u_ctrl (
      .clk       (clk),
      .srst      (srst),
      .start     (start_i),
      .cnt_zero  (cnt_zero),
      .eff_width (eff_width),
      .cnt_load  (cnt_load),
      .cnt_val   (cnt_val),
      .accept    (accept),
      .phase     (phase)
   );

   assign reset_pulse_o = (phase == PH_HIGH);
   assign busy_o        = (phase != PH_IDLE);
   assign done_o        = (phase == PH_TAIL) && cnt_zero;

endmodule

// File: rtl/dprs_seq_chk.sv
module dprs_seq_chk #(
   parameter int WIDTH_W    = 16,
   parameter int MIN_PULSE  = 110
) (
   input logic               clk,
   input logic               srst,
   input logic               start_i,
   input logic [WIDTH_W-1:0] pulse_width_i,
   input logic               reset_pulse_o,
   input logic               busy_o,
   input logic               done_o
);

   localparam int RUN_W = WIDTH_W + 1;

   logic [RUN_W-1:0] run_cnt;
   logic             seen_clk;

   always_ff @(posedge clk) begin
      if (srst) begin
         run_cnt  <= '0;
         seen_clk <= 1'b0;
      end else begin
         seen_clk <= 1'b1;
         if (reset_pulse_o) begin
            if (run_cnt != {RUN_W{1'b1}})
               run_cnt <= run_cnt + RUN_W'(1);
         end else begin
            run_cnt <= '0;
         end
      end
   end

   // R6
   pulse_in_busy_chk: assert property (@(posedge clk) disable iff (srst)
      reset_pulse_o |-> busy_o);

   // R6
   done_in_busy_chk: assert property (@(posedge clk) disable iff (srst)
      done_o |-> busy_o);

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (srst)
      done_o |=> !done_o);

   // R5
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (srst)
      done_o |=> !busy_o);

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (srst)
      (start_i && !busy_o) |=> busy_o);

   // R4
   min_width_chk: assert property (@(posedge clk) disable iff (srst)
      (seen_clk && !reset_pulse_o && run_cnt != '0) |-> run_cnt >= RUN_W'(MIN_PULSE));

   // R9
   reset_idle_chk: assert property (@(posedge clk)
      $past(srst) |-> (!busy_o && !reset_pulse_o && !done_o));

endmodule

bind dprs_seq dprs_seq_chk #(
   .WIDTH_W   (WIDTH_W),
   .MIN_PULSE (MIN_PULSE)
) u_chk (
   .clk           (clk),
   .srst          (srst),
   .start_i       (start_i),
   .pulse_width_i (pulse_width_i),
   .reset_pulse_o (reset_pulse_o),
   .busy_o        (busy_o),
   .done_o        (done_o)
);

// File: tb/dprs_seq_tb.sv
module dprs_seq_tb;

   localparam int LEAD = 10;
   localparam int TAIL = 5;
   localparam int MINW = 110;

   logic        clk = 1'b0;
   logic        srst;
   logic        start_i;
   logic [15:0] pulse_width_i;
   logic        reset_pulse_o;
   logic        busy_o;
   logic        done_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   dprs_seq u_dut (
      .clk           (clk),
      .srst          (srst),
      .start_i       (start_i),
      .pulse_width_i (pulse_width_i),
      .reset_pulse_o (reset_pulse_o),
      .busy_o        (busy_o),
      .done_o        (done_o)
   );

   function automatic int eff_n(input int req);
      return (req < MINW) ? MINW : req;
   endfunction

   // expected {busy, pulse, done} at cycle i of a sequence of width n
   function automatic logic [2:0] exp_out(input int i, input int n);
      int total;
      logic b, p, d;
      total = LEAD + 3 * n + TAIL;
      b = (i < total);
      p = ((i >= LEAD) && (i < LEAD + n)) ||
          ((i >= LEAD + 2 * n) && (i < LEAD + 3 * n));
      d = (i == total - 1);
      return {b, p, d};
   endfunction

   function automatic string req_of(input int i, input int n);
      if (i < LEAD) return "R2";
      if (i < LEAD + 3 * n) return "R3/R4";
      return "R5/R6";
   endfunction

   task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {busy,pulse,done} actual %b expected %b", tag, act, exp);
      end
   endtask

   // runs one sequence; noise!=0 adds busy-time starts (R7) and width changes (R8)
   task automatic run_seq(input int req, input bit noise);
      int n, total;
      n = eff_n(req);
      total = LEAD + 3 * n + TAIL;
      start_i       = 1'b1;
      pulse_width_i = 16'(req);
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i <= total; i++) begin
         check(req_of(i, n), {busy_o, reset_pulse_o, done_o}, exp_out(i, n));
         if (i < total && noise) begin
            start_i       = 1'($urandom_range(0, 1));
            pulse_width_i = 16'($urandom_range(0, 65535));
         end else begin
            start_i = 1'b0;
         end
         if (i < total) @(negedge clk);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      srst          = 1'b1;
      start_i       = 1'b0;
      pulse_width_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1", {busy_o, reset_pulse_o, done_o}, 3'b000);
      srst = 1'b0;
      @(negedge clk);
      check("R1", {busy_o, reset_pulse_o, done_o}, 3'b000);

      // R4 directed widths around the floor, including zero
      run_seq(0, 1'b0);
      run_seq(1, 1'b0);
      run_seq(109, 1'b0);
      // R10: back-to-back starts right after done
      run_seq(110, 1'b0);
      run_seq(111, 1'b0);
      // R7 / R8: noisy start and width during busy
      run_seq(150, 1'b1);
      run_seq(40, 1'b1);

      // random widths
      for (int k = 0; k < 8; k++)
         run_seq(int'($urandom_range(0, 400)), k[0]);

      // R9: system reset in mid sequence
      start_i       = 1'b1;
      pulse_width_i = 16'd200;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      repeat (LEAD + 50) @(negedge clk);
      check("R9 mid pulse", {busy_o, reset_pulse_o, done_o}, 3'b110);
      srst = 1'b1;
      @(negedge clk);
      check("R9", {busy_o, reset_pulse_o, done_o}, 3'b000);
      srst = 1'b0;
      repeat (20) begin
         @(negedge clk);
         check("R9 stays idle", {busy_o, reset_pulse_o, done_o}, 3'b000);
      end
      run_seq(120, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule